// File: doc/BRIEF.md
# Capture/Compare Timer Channel

This block is one channel of a capture/compare unit that hangs off a shared free-running 16-bit counter. The mode byte picks one of six functions. In capture mode the channel records the counter on a chosen edge of an external pin. In software-timer mode it flags when the counter reaches a set value. In high-speed-output mode it toggles a pin on that match. In frequency-output mode it generates a square wave. It can also act as a pulse-width modulator with a cycle of 8 to 11 bits, or with the full 16 bits.

The counter itself lives outside the block. The channel sees the counter value and a strobe, `cnt_adv_i`, that says the counter steps at the coming clock edge. Every boundary and match event is qualified by that strobe, so each counter value is seen once. The channel raises a sticky event flag and a gated interrupt request. The shared counter-overflow flag and its gated request are also produced here. That overflow is taken from the short PWM boundary or from the full 16-bit rollover, as the shared setting selects.

Top module: `cc_channel`

## Requirements
- R1: While reset is asserted, and right after it, the output pin, both flags, both requests and the compare/capture readback are all zero.
- R2: The mode byte selects capture when bits 7 and 6 are 0, bits 3..1 are 0, and at least one of bit 5 (rising enable) and bit 4 (falling enable) is set. A qualifying edge on `cap_pin_i` passes two synchronizer stages and is detected one cycle later. The counter value present at the third rising clock edge after the pin change is then copied into the readback register, and the event flag is set at that same edge. Rising-only mode ignores falling edges, and falling-only mode ignores rising edges.
- R3: A mode byte with bit 6 at 0 and any of bits 3..1 set captures nothing, even when an edge-enable bit is set.
- R4: Mode bits {7,6,3,2,1} = 0,1,1,0,0 select the software timer. A clock edge at which `cnt_adv_i` is high and the counter equals the compare value sets the event flag. The output pin is left unchanged.
- R5: Mode bits {7,6,3,2,1} = 0,1,1,1,0 select high-speed output. This mode behaves as in R4 and also toggles the output pin on each match.
- R6: Mode bits {7,6,3,2,1} = 0,1,0,1,1 select frequency output. When the low counter byte equals the low compare byte with `cnt_adv_i` high, the output pin toggles and the high compare byte is added, modulo 256, to the low compare byte.
- R7: Mode bits {7,6,3,2,1} = 0,1,0,0,1 select short PWM. The cycle width N is 8 plus `cyc_sel_i` (0..3, giving 8..11 bits). The output is low while the low N counter bits are below the low N duty bits, and high otherwise.
- R8: While a PWM mode is active, a new compare value becomes the duty value only at the edge where the counter passes its cycle boundary (low N bits all ones with `cnt_adv_i` high, or all 16 bits for 16-bit PWM). Outside PWM modes the duty value follows the compare register every cycle.
- R9: Mode bits {7,6,3,2,1} = 1,1,0,0,1 select 16-bit PWM. The output is high when the full counter is at least the duty value, and low otherwise.
- R10: Mode bit 0 enables the interrupt. `ev_irq_o` is high exactly when the event flag is set and bit 0 is 1.
- R11: With `short_ovf_i` high, the overflow flag is set at the N-bit boundary. With it low, the flag is set only at the 16-bit rollover.
- R12: `ovf_irq_o` is high exactly when the overflow flag is set and `ovf_ie_i` is 1.
- R13: Both flags are sticky. A clear pulse resets a flag, but a set event in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 8 | Channel mode byte |
| cyc_sel_i | input | 2 | Shared short-PWM width, 8 plus value |
| short_ovf_i | input | 1 | Take overflow from the N-bit boundary |
| ovf_ie_i | input | 1 | Overflow interrupt enable |
| cmp_wr_i | input | 1 | Write strobe for the compare register |
| cmp_wdata_i | input | 16 | Compare write data |
| ev_clr_i | input | 1 | Clear pulse for the event flag |
| ovf_clr_i | input | 1 | Clear pulse for the overflow flag |
| cnt_i | input | 16 | Shared counter value |
| cnt_adv_i | input | 1 | Counter steps at the coming edge |
| cap_pin_i | input | 1 | External capture pin, asynchronous |
| cmp_rdata_o | output | 16 | Compare/capture register readback |
| ch_out_o | output | 1 | Channel output pin |
| ev_flag_o | output | 1 | Sticky event flag |
| ev_irq_o | output | 1 | Gated event request |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| ovf_irq_o | output | 1 | Gated overflow request |

## Verification
The assertions assume two things about the inputs. First, a software write to the compare register does not fall in the same cycle as a capture. Second, the counter advances only when `cnt_adv_i` is high, so a match or boundary is seen once per counter value. The bench keeps the counter frozen with the strobe low whenever it writes the compare register or changes mode. It uses a separate cycle, apart from any capture, for each write. When it needs to exercise a match or boundary, it raises the strobe only for a contiguous run of counter values.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic [2:0] {
    CM_IDLE, CM_CAPTURE, CM_TIMER, CM_HSO, CM_FREQ, CM_PWMN, CM_PWM16
  } cc_mode_e;

  localparam int unsigned MB_IE   = 0;
  localparam int unsigned MB_PWM  = 1;
  localparam int unsigned MB_TOG  = 2;
  localparam int unsigned MB_MAT  = 3;
  localparam int unsigned MB_FALL = 4;
  localparam int unsigned MB_RISE = 5;
  localparam int unsigned MB_CMP  = 6;
  localparam int unsigned MB_WIDE = 7;
endpackage

// File: rtl/cc_mode_dec.sv
module cc_mode_dec
  import cc_pkg::*;
(
  input  logic [7:0] mode_i,
  output cc_mode_e   mode_o,
  output logic       rise_en_o,
  output logic       fall_en_o,
  output logic       irq_en_o
);
  logic [3:0] fn_bits;

  always_comb begin
    fn_bits   = {mode_i[MB_WIDE], mode_i[MB_MAT], mode_i[MB_TOG], mode_i[MB_PWM]};
    rise_en_o = mode_i[MB_RISE];
    fall_en_o = mode_i[MB_FALL];
    irq_en_o  = mode_i[MB_IE];
    mode_o    = CM_IDLE;
    if (!mode_i[MB_CMP]) begin
      if (fn_bits == 4'b0000 && (mode_i[MB_RISE] || mode_i[MB_FALL]))
        mode_o = CM_CAPTURE;
    end else begin
      case (fn_bits)
        4'b0100: mode_o = CM_TIMER;
        4'b0110: mode_o = CM_HSO;
        4'b0011: mode_o = CM_FREQ;
        4'b0001: mode_o = CM_PWMN;
        4'b1001: mode_o = CM_PWM16;
        default: mode_o = CM_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cc_edge_cap.sv
module cc_edge_cap #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic en_i,
  input  logic rise_en_i,
  input  logic fall_en_i,
  output logic cap_ev_o
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, prev_d;
  logic                   lvl;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], pin_i};
    lvl    = sync_q[SYNC_STAGES-1];
    prev_d = lvl;
    cap_ev_o = en_i && ((rise_en_i && lvl && !prev_q) ||
                        (fall_en_i && !lvl && prev_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  // R2: a detected edge needs the synchronized level to have changed
  a_r2_edge_real: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev_o |-> (sync_q[SYNC_STAGES-1] != prev_q));
endmodule

// File: rtl/cc_cmp_core.sv
module cc_cmp_core
  import cc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cc_mode_e         mode_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             adv_i,
  input  logic             cap_ev_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cmp_o,
  output logic             match_ev_o,
  output logic             tog_o
);
  localparam int unsigned FB = CNT_W / 2;

  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic             cmp_en;
  logic             tog_q, tog_d, tog_en;
  logic             match_full, freq_hit;
  logic [FB-1:0]    lo_next;

  always_comb begin
    match_full = adv_i && (cnt_i == cmp_q);
    match_ev_o = match_full && (mode_i == CM_TIMER || mode_i == CM_HSO);
    freq_hit   = adv_i && (mode_i == CM_FREQ) && (cnt_i[FB-1:0] == cmp_q[FB-1:0]);
    lo_next    = cmp_q[FB-1:0] + cmp_q[CNT_W-1:FB];
    cmp_en     = wr_i || cap_ev_i || freq_hit;
    if (wr_i)          cmp_d = wdata_i;
    else if (cap_ev_i) cmp_d = cnt_i;
    else if (freq_hit) cmp_d = {cmp_q[CNT_W-1:FB], lo_next};
    else               cmp_d = cmp_q;
    tog_en = freq_hit || (match_full && mode_i == CM_HSO);
    tog_d  = !tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
      tog_q <= 1'b0;
    end else begin
      if (cmp_en) cmp_q <= cmp_d;
      if (tog_en) tog_q <= tog_d;
    end
  end

  assign cmp_o = cmp_q;
  assign tog_o = tog_q;

  // R2: a capture copies the counter of that cycle
  a_r2_cap_value: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_ev_i && !wr_i) |=> (cmp_q == $past(cnt_i)));
endmodule

// File: rtl/cc_pwm.sv
module cc_pwm #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned MIN_W = 8,
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active_i,
  input  logic             wide_i,
  input  logic [SEL_W-1:0] cyc_sel_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             adv_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic             pwm_o,
  output logic             ovf_n_o,
  output logic             ovf_16_o
);
  localparam int unsigned SHIFT_BASE = CNT_W - MIN_W;
  localparam logic [CNT_W-1:0] ONES = '1;

  logic [CNT_W-1:0] duty_q, duty_d, low_mask;
  logic             duty_en, boundary;
  int unsigned      sh;

  always_comb begin
    sh       = SHIFT_BASE - 32'(cyc_sel_i);
    low_mask = ONES >> sh;
    ovf_n_o  = adv_i && ((cnt_i & low_mask) == low_mask);
    ovf_16_o = adv_i && (cnt_i == ONES);
    boundary = wide_i ? ovf_16_o : ovf_n_o;
    duty_en  = !active_i || boundary;
    duty_d   = cmp_i;
    if (wide_i) pwm_o = (cnt_i >= duty_q);
    else        pwm_o = ((cnt_i & low_mask) >= (duty_q & low_mask));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       duty_q <= '0;
    else if (duty_en) duty_q <= duty_d;
  end

  // R8: duty only moves at the cycle boundary while PWM runs
  a_r8_duty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && !boundary) |=> $stable(duty_q));
endmodule

// File: rtl/cc_channel.sv
module cc_channel
  import cc_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned MIN_W       = 8,
  parameter int unsigned SEL_W       = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       mode_i,
  input  logic [SEL_W-1:0] cyc_sel_i,
  input  logic             short_ovf_i,
  input  logic             ovf_ie_i,
  input  logic             cmp_wr_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  input  logic             ev_clr_i,
  input  logic             ovf_clr_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_adv_i,
  input  logic             cap_pin_i,
  output logic [CNT_W-1:0] cmp_rdata_o,
  output logic             ch_out_o,
  output logic             ev_flag_o,
  output logic             ev_irq_o,
  output logic             ovf_flag_o,
  output logic             ovf_irq_o
);
  logic [1:0] rst_sq;
  logic       rst_n_int;
  cc_mode_e   dec_mode;
  logic       rise_en, fall_en, irq_en;
  logic       cap_ev, match_ev, tog, pwm_out, ovf_n, ovf_16;
  logic       pwm_active, pwm_wide;
  logic       ev_q, ev_d, ev_en, ovf_q, ovf_d, ovf_en, ev_set, ovf_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= 2'b00;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_n_int = rst_sq[1];

  cc_mode_dec u_dec (
    .mode_i(mode_i), .mode_o(dec_mode),
    .rise_en_o(rise_en), .fall_en_o(fall_en), .irq_en_o(irq_en)
  );

  cc_edge_cap #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk(clk), .rst_n(rst_n_int), .pin_i(cap_pin_i),
    .en_i(dec_mode == CM_CAPTURE), .rise_en_i(rise_en), .fall_en_i(fall_en),
    .cap_ev_o(cap_ev)
  );

  cc_cmp_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n_int), .mode_i(dec_mode), .cnt_i(cnt_i),
    .adv_i(cnt_adv_i), .cap_ev_i(cap_ev), .wr_i(cmp_wr_i), .wdata_i(cmp_wdata_i),
    .cmp_o(cmp_rdata_o), .match_ev_o(match_ev), .tog_o(tog)
  );

  assign pwm_active = (dec_mode == CM_PWMN) || (dec_mode == CM_PWM16);
  assign pwm_wide   = (dec_mode == CM_PWM16);

  cc_pwm #(.CNT_W(CNT_W), .MIN_W(MIN_W), .SEL_W(SEL_W)) u_pwm (
    .clk(clk), .rst_n(rst_n_int), .active_i(pwm_active), .wide_i(pwm_wide),
    .cyc_sel_i(cyc_sel_i), .cnt_i(cnt_i), .adv_i(cnt_adv_i), .cmp_i(cmp_rdata_o),
    .pwm_o(pwm_out), .ovf_n_o(ovf_n), .ovf_16_o(ovf_16)
  );

  always_comb begin
    ev_set  = cap_ev || match_ev;
    ev_en   = ev_set || ev_clr_i;
    ev_d    = ev_set;
    ovf_set = short_ovf_i ? ovf_n : ovf_16;
    ovf_en  = ovf_set || ovf_clr_i;
    ovf_d   = ovf_set;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      ev_q  <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (ev_en)  ev_q  <= ev_d;
      if (ovf_en) ovf_q <= ovf_d;
    end
  end

  assign ev_flag_o  = ev_q;
  assign ovf_flag_o = ovf_q;
  assign ev_irq_o   = ev_q && irq_en;
  assign ovf_irq_o  = ovf_q && ovf_ie_i;
  assign ch_out_o   = pwm_active ? pwm_out : tog;

  // R13: flags hold until cleared; a set beats a same-cycle clear
  a_r13_ev_sticky: assert property (@(posedge clk) disable iff (!rst_n_int)
    (ev_flag_o && !ev_clr_i) |=> ev_flag_o);
  a_r13_set_wins: assert property (@(posedge clk) disable iff (!rst_n_int)
    ev_set |=> ev_flag_o);
  a_r13_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n_int)
    (ovf_flag_o && !ovf_clr_i) |=> ovf_flag_o);
  // R5: each high-speed match flips the pin
  a_r5_hso_toggle: assert property (@(posedge clk) disable iff (!rst_n_int)
    (dec_mode == CM_HSO && match_ev) |=>
      ((dec_mode != CM_HSO) || (ch_out_o != $past(ch_out_o))));
endmodule

// File: tb/test_cc_channel.sv
`timescale 1ns/1ps
module test_cc_channel;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  mode;
  logic [1:0]  cyc_sel;
  logic        short_ovf, ovf_ie, cmp_wr, ev_clr, ovf_clr, adv, pin;
  logic [15:0] wdata, cnt;
  logic [15:0] rdata;
  logic        ch_out, ev_flag, ev_irq, ovf_flag, ovf_irq;

  always #10 clk = ~clk;

  cc_channel i_cc_channel (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .cyc_sel_i(cyc_sel),
    .short_ovf_i(short_ovf), .ovf_ie_i(ovf_ie), .cmp_wr_i(cmp_wr),
    .cmp_wdata_i(wdata), .ev_clr_i(ev_clr), .ovf_clr_i(ovf_clr),
    .cnt_i(cnt), .cnt_adv_i(adv), .cap_pin_i(pin),
    .cmp_rdata_o(rdata), .ch_out_o(ch_out), .ev_flag_o(ev_flag),
    .ev_irq_o(ev_irq), .ovf_flag_o(ovf_flag), .ovf_irq_o(ovf_irq)
  );

  localparam int S_OUT = 0, S_EV = 1, S_IRQ = 2, S_RD = 3, S_OVF = 4, S_OIRQ = 5;

  logic [15:0] exp_q[$];
  int          sel_q[$];
  string       tag_q[$];
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  function automatic logic [15:0] observe(int sel);
    case (sel)
      S_OUT:   return {15'd0, ch_out};
      S_EV:    return {15'd0, ev_flag};
      S_IRQ:   return {15'd0, ev_irq};
      S_RD:    return rdata;
      S_OVF:   return {15'd0, ovf_flag};
      default: return {15'd0, ovf_irq};
    endcase
  endfunction

  // monitor: pops expected items and compares at the falling edge
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      logic [15:0] e, o;
      string t;
      int s;
      e = exp_q.pop_front();
      s = sel_q.pop_front();
      t = tag_q.pop_front();
      o = observe(s);
      n_chk++;
      if (o !== e) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h", t, o, e);
      end
    end
  end

  task automatic want(string tag, int sel, logic [15:0] v);
    exp_q.push_back(v);
    sel_q.push_back(sel);
    tag_q.push_back(tag);
  endtask

  task automatic flush();
    @(negedge clk); #1;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    if (adv) cnt = cnt + 16'd1;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic clr_ev();
    ev_clr = 1'b1; tick(); ev_clr = 1'b0;
  endtask

  task automatic write_cmp(logic [15:0] v);
    wdata = v; cmp_wr = 1'b1; tick(); cmp_wr = 1'b0;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hang expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b1; mode = 8'h00; cyc_sel = 2'd0; short_ovf = 1'b0; ovf_ie = 1'b0;
    cmp_wr = 1'b0; wdata = 16'h0; ev_clr = 1'b0; ovf_clr = 1'b0;
    cnt = 16'h0; adv = 1'b0; pin = 1'b0;
    #1 rst_n = 1'b0;
    ticks(2);
    want("R1 out", S_OUT, 0); want("R1 ev", S_EV, 0); want("R1 irq", S_IRQ, 0);
    want("R1 rd", S_RD, 0); want("R1 ovf", S_OVF, 0); want("R1 oirq", S_OIRQ, 0);
    flush();
    rst_n = 1'b1;
    ticks(3);
    want("R1 after release", S_EV, 0); flush();

    // R2 rising only
    mode = 8'h20; cnt = 16'd100; pin = 1'b1;
    ticks(2); want("R2 sync delay", S_EV, 0); flush();
    tick(); want("R2 rise flag", S_EV, 1); want("R2 rise value", S_RD, 16'd100); flush();
    clr_ev();
    pin = 1'b0; cnt = 16'd200; ticks(4);
    want("R2 fall ignored", S_EV, 0); want("R2 fall ignored rd", S_RD, 16'd100); flush();
    // R2 falling only
    mode = 8'h10; pin = 1'b1; cnt = 16'd250; ticks(4);
    want("R2 rise ignored", S_EV, 0); flush();
    pin = 1'b0; cnt = 16'd300; ticks(4);
    want("R2 fall flag", S_EV, 1); want("R2 fall value", S_RD, 16'd300); flush();
    clr_ev();
    // R2 both edges, R10 gating
    mode = 8'h30; pin = 1'b1; cnt = 16'd400; ticks(4);
    want("R2 any rise", S_RD, 16'd400); want("R2 any flag", S_EV, 1);
    want("R10 irq off", S_IRQ, 0); flush();
    mode = 8'h31;
    want("R10 irq on", S_IRQ, 1); flush();
    clr_ev();
    want("R10 irq after clear", S_IRQ, 0); flush();
    pin = 1'b0; cnt = 16'd500; ticks(4);
    want("R2 any fall", S_RD, 16'd500); flush();
    // R3 illegal capture setting
    mode = 8'h32; clr_ev();
    pin = 1'b1; cnt = 16'd600; ticks(4);
    want("R3 no capture flag", S_EV, 0); want("R3 no capture rd", S_RD, 16'd500); flush();
    // R13 set beats clear
    mode = 8'h30; pin = 1'b0; cnt = 16'd700;
    ticks(2); ev_clr = 1'b1; tick(); ev_clr = 1'b0;
    want("R13 set wins", S_EV, 1); want("R13 value", S_RD, 16'd700); flush();
    ticks(2); want("R13 sticky", S_EV, 1); flush();

    // R4 software timer
    mode = 8'h48; cnt = 16'd0; write_cmp(16'd20); clr_ev();
    cnt = 16'd15; adv = 1'b1;
    ticks(5); want("R4 before match", S_EV, 0); flush();
    tick(); want("R4 match flag", S_EV, 1); want("R4 out unchanged", S_OUT, 0); flush();
    adv = 1'b0;

    // R5 high-speed output
    mode = 8'h4C; clr_ev();
    cnt = 16'd18; adv = 1'b1;
    ticks(2); want("R5 before match", S_OUT, 0); flush();
    tick(); want("R5 toggle", S_OUT, 1); want("R5 flag", S_EV, 1); flush();
    adv = 1'b0; cnt = 16'd18; adv = 1'b1;
    ticks(3); want("R5 toggle back", S_OUT, 0); flush();
    adv = 1'b0;

    // R6 frequency output
    mode = 8'h46; write_cmp(16'h0510);
    cnt = 16'h000E; adv = 1'b1;
    ticks(3); want("R6 first toggle", S_OUT, 1); want("R6 step", S_RD, 16'h0515); flush();
    ticks(4); want("R6 hold", S_OUT, 1); flush();
    tick(); want("R6 second toggle", S_OUT, 0); want("R6 step2", S_RD, 16'h051A); flush();
    adv = 1'b0;

    // R7 short PWM
    write_cmp(16'h0040); tick();
    mode = 8'h42; cyc_sel = 2'd0; tick();
    cnt = 16'h0123; want("R7 n8 low", S_OUT, 0); flush();
    cnt = 16'h0140; want("R7 n8 at duty", S_OUT, 1); flush();
    cnt = 16'h013F; want("R7 n8 below", S_OUT, 0); flush();
    cyc_sel = 2'd1;
    cnt = 16'h0123; want("R7 n9 high", S_OUT, 1); flush();
    cnt = 16'h0230; want("R7 n9 low", S_OUT, 0); flush();
    cyc_sel = 2'd3;
    cnt = 16'h0830; want("R7 n11 low", S_OUT, 0); flush();
    cnt = 16'h0041; want("R7 n11 high", S_OUT, 1); flush();

    // R8 duty reload at boundary, R11 short overflow
    cyc_sel = 2'd0; write_cmp(16'h0080);
    cnt = 16'h0150; want("R8 old duty kept", S_OUT, 1); flush();
    short_ovf = 1'b1; ovf_clr = 1'b1; tick(); ovf_clr = 1'b0;
    cnt = 16'h01FF; adv = 1'b1; tick(); adv = 1'b0;
    cnt = 16'h0350; want("R8 new duty", S_OUT, 0); want("R11 short ovf", S_OVF, 1); flush();
    short_ovf = 1'b0; ovf_clr = 1'b1; tick(); ovf_clr = 1'b0;
    cnt = 16'h02FF; adv = 1'b1; tick(); adv = 1'b0;
    want("R11 no short ovf", S_OVF, 0); flush();
    cnt = 16'hFFFF; adv = 1'b1; tick(); adv = 1'b0;
    want("R11 16-bit ovf", S_OVF, 1); flush();
    // R12
    ovf_ie = 1'b0; want("R12 gated off", S_OIRQ, 0); flush();
    ovf_ie = 1'b1; want("R12 gated on", S_OIRQ, 1); flush();

    // R9 16-bit PWM
    mode = 8'h48; write_cmp(16'h1234); tick();
    mode = 8'hC2; tick();
    cnt = 16'h1233; want("R9 below", S_OUT, 0); flush();
    cnt = 16'h1234; want("R9 at duty", S_OUT, 1); flush();
    cnt = 16'h0034; want("R9 upper bits", S_OUT, 0); flush();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule